// File: doc/BRIEF.md
# Byte-Lane Static RAM Model

A synthesizable stand-in for an asynchronous static RAM with a 16-bit word split into a lower and an upper byte lane. Five active-low controls (chip select, write strobe, output gate and one enable per byte lane) are decoded into one of five operations: idle, no-lane, hold, read and write. Each operation is then applied lane by lane, so a single access can touch either byte or both.

The model has no internal tri-state. It returns a registered read-data bus and a per-lane drive vector, and a wrapper at the pad or on the board turns each lane of the bus into a tri-state driver. Writes are taken at the rising clock edge while the write condition holds. Read data appears one cycle after the cycle in which the read condition is present. The address width is a parameter. The full-size part uses 18 address bits, and simulations use a smaller array.

Top module: `sram_lane_model`

## Requirements
- R1: While rst_ni is low and after its release, until the first access, drive_o is 2'b00 and rdata_o is 16'h0000.
- R2: With ce_ni high, the cycle that follows has drive_o equal to 2'b00, and no stored byte changes, whatever we_ni, oe_ni and be_ni are.
- R3: With ce_ni low and both be_ni bits high, no stored byte changes and the next cycle has drive_o equal to 2'b00.
- R4: With ce_ni and we_ni both low, the clock edge stores wdata_i[7:0] at addr_i when be_ni[0] is low and stores wdata_i[15:8] at addr_i when be_ni[1] is low. A lane whose enable is high keeps its old byte, and oe_ni has no effect on the write.
- R5: With ce_ni low, we_ni high and oe_ni low, each lane whose be_ni bit is low is driven in the next cycle (drive_o bit set) with the byte stored at addr_i.
- R6: In the cycle after a write (ce_ni and we_ni low), drive_o is 2'b00 even when oe_ni is low.
- R7: With oe_ni high and we_ni high, drive_o is 2'b00 in the next cycle for all four be_ni values.
- R8: The rdata_o bits of any lane whose drive_o bit is clear read as zero.
- R9: drive_o and rdata_o reflect the controls sampled at the previous clock edge, so they have exactly one cycle of latency.
- R10: Every address from 0 to 2**AW-1 holds its own word. Words at the lowest and highest address do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the output registers |
| ce_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output gate, active low |
| be_ni | input | 2 | Byte-lane enables, active low; bit 0 lower byte, bit 1 upper byte |
| addr_i | input | AW | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data, zero on undriven lanes |
| drive_o | output | 2 | Per-lane drive enable for an external tri-state; bit 0 lower, bit 1 upper |

## Verification
A wrong operation decode shows up within one clock edge as a drive_o bit set in a cycle where it must be clear, or a lane left undriven during a read. A stray or missing write to a lane stays hidden until that address is read back. It then appears as one wrong byte in rdata_o, one cycle after the read is issued. For that reason every masked or suppressed write is followed by a read of the same word.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_NOLANE,
    OP_HOLD,
    OP_READ,
    OP_WRITE
  } op_e;
endpackage

// File: rtl/sram_lane_decode.sv
module sram_lane_decode
  import sram_lane_pkg::*;
#(
  parameter int NL = LANES
) (
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [NL-1:0] be_ni,
  output op_e           op_o,
  output logic [NL-1:0] wr_o,
  output logic [NL-1:0] rd_o
);
  logic [NL-1:0] sel;

  always_comb begin
    sel = ~be_ni;
    if (ce_ni)             op_o = OP_IDLE;
    else if (sel == '0)    op_o = OP_NOLANE;
    else if (!we_ni)       op_o = OP_WRITE;
    else if (!oe_ni)       op_o = OP_READ;
    else                   op_o = OP_HOLD;
  end

  always_comb begin
    wr_o = (op_o == OP_WRITE) ? sel : '0;
    rd_o = (op_o == OP_READ)  ? sel : '0;
  end
endmodule

// File: rtl/sram_lane_store.sv
module sram_lane_store #(
  parameter int AW = 10,
  parameter int NL = 2,
  parameter int LW = 8
) (
  input  logic             clk_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NL-1:0]    wr_i,
  input  logic [NL*LW-1:0] wdata_i,
  output logic [NL*LW-1:0] q_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_i[g]) mem[addr_i] <= wdata_i[g*LW +: LW];
    end

    assign q_o[g*LW +: LW] = mem[addr_i];
  end
endmodule

// File: rtl/sram_lane_out.sv
module sram_lane_out #(
  parameter int NL = 2,
  parameter int LW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NL-1:0]    rd_i,
  input  logic [NL*LW-1:0] q_i,
  output logic [NL*LW-1:0] rdata_o,
  output logic [NL-1:0]    drive_o
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        drive_o[g]           <= 1'b0;
        rdata_o[g*LW +: LW]  <= '0;
      end else begin
        drive_o[g]           <= rd_i[g];
        rdata_o[g*LW +: LW]  <= rd_i[g] ? q_i[g*LW +: LW] : '0;
      end
    end
  end
endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
  import sram_lane_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [LANES-1:0]  be_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LANES-1:0]  drive_o
);
  op_e              op;
  logic [LANES-1:0] wr_lane;
  logic [LANES-1:0] rd_lane;
  logic [DATA_W-1:0] q;

  sram_lane_decode #(.NL(LANES)) i_decode (
    .ce_ni (ce_ni),
    .we_ni (we_ni),
    .oe_ni (oe_ni),
    .be_ni (be_ni),
    .op_o  (op),
    .wr_o  (wr_lane),
    .rd_o  (rd_lane)
  );

  sram_lane_store #(.AW(AW), .NL(LANES), .LW(LANE_W)) i_store (
    .clk_i   (clk_i),
    .addr_i  (addr_i),
    .wr_i    (wr_lane),
    .wdata_i (wdata_i),
    .q_o     (q)
  );

  sram_lane_out #(.NL(LANES), .LW(LANE_W)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_lane),
    .q_i     (q),
    .rdata_o (rdata_o),
    .drive_o (drive_o)
  );
endmodule

// File: rtl/sram_lane_checker.sv
module sram_lane_checker #(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          we_ni,
  input logic          oe_ni,
  input logic [1:0]    be_ni,
  input logic [AW-1:0] addr_i,
  input logic [15:0]   rdata_o,
  input logic [1:0]    drive_o
);
  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (drive_o == 2'b00)); // R2
  AST_NOLANE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && be_ni == 2'b11) |=> (drive_o == 2'b00)); // R3
  AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !we_ni) |=> (drive_o == 2'b00)); // R6
  AST_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni && we_ni) |=> (drive_o == 2'b00)); // R7
  AST_READ_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && we_ni && !oe_ni) |=> (drive_o == ~$past(be_ni))); // R5
  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o[0] |-> (rdata_o[7:0] == 8'h00)); // R8
  AST_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o[1] |-> (rdata_o[15:8] == 8'h00)); // R8
endmodule

bind sram_lane_model sram_lane_checker #(.AW(AW)) i_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ce_ni   (ce_ni),
  .we_ni   (we_ni),
  .oe_ni   (oe_ni),
  .be_ni   (be_ni),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .drive_o (drive_o)
);

// File: tb/test_sram_lane_model.sv
`timescale 1ns/1ps
module test_sram_lane_model;
  localparam int AW = 10;
  localparam logic [AW-1:0] TOP = '1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1;
  logic [1:0]    be_ni = 2'b11;
  logic [AW-1:0] addr_i = '0;
  logic [15:0]   wdata_i = '0;
  logic [15:0]   rdata_o;
  logic [1:0]    drive_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sram_lane_model #(.AW(AW)) i_sram_lane_model (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
    .be_ni(be_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .drive_o(drive_o)
  );

  task automatic chk(input string req, input logic [1:0] edrv, input logic [15:0] edat);
    checks++;
    if (drive_o !== edrv || rdata_o !== edat) begin
      errors++;
      $display("FAIL %s drive=%b data=%h expected drive=%b data=%h", req, drive_o, rdata_o, edrv, edat);
    end
  endtask

  // apply one cycle of controls; outputs then show that cycle's result
  task automatic cyc(input logic ce, we, oe, input logic [1:0] be,
                     input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    ce_ni = ce; we_ni = we; oe_ni = oe; be_ni = be; addr_i = a; wdata_i = d;
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input string req, input logic [1:0] be, input logic [AW-1:0] a,
                    input logic [1:0] edrv, input logic [15:0] edat);
    cyc(1'b0, 1'b1, 1'b0, be, a, 16'h0);
    chk(req, edrv, edat);
  endtask

  task automatic t_reset;
    #23;
    chk("R1 in reset", 2'b00, 16'h0000);
    @(negedge clk); rst_ni = 1'b1;
    cyc(1'b1, 1'b1, 1'b1, 2'b11, '0, 16'h0);
    chk("R1 after release", 2'b00, 16'h0000);
  endtask

  task automatic t_full_words;
    cyc(1'b0, 1'b0, 1'b0, 2'b00, '0, 16'hA55A);
    chk("R6 write with oe low", 2'b00, 16'h0000);
    cyc(1'b0, 1'b0, 1'b1, 2'b00, TOP, 16'h1234);
    chk("R4 write with oe high", 2'b00, 16'h0000);
    rd("R5 R10 read low address", 2'b00, '0, 2'b11, 16'hA55A);
    rd("R10 read top address", 2'b00, TOP, 2'b11, 16'h1234);
  endtask

  task automatic t_byte_lanes;
    cyc(1'b0, 1'b0, 1'b1, 2'b00, 10'd5, 16'hC3C3);
    cyc(1'b0, 1'b0, 1'b1, 2'b10, 10'd5, 16'hEE11);
    rd("R4 lower lane write", 2'b00, 10'd5, 2'b11, 16'hC311);
    cyc(1'b0, 1'b0, 1'b0, 2'b01, 10'd5, 16'h22FF);
    rd("R4 upper lane write", 2'b00, 10'd5, 2'b11, 16'h2211);
    rd("R5 R8 lower lane read", 2'b10, 10'd5, 2'b01, 16'h0011);
    rd("R5 R8 upper lane read", 2'b01, 10'd5, 2'b10, 16'h2200);
  endtask

  task automatic t_deselect;
    cyc(1'b1, 1'b0, 1'b0, 2'b00, '0, 16'h0000);
    chk("R2 deselect during write strobe", 2'b00, 16'h0000);
    cyc(1'b1, 1'b1, 1'b0, 2'b00, '0, 16'h0000);
    chk("R2 deselect during read request", 2'b00, 16'h0000);
    rd("R2 word unchanged", 2'b00, '0, 2'b11, 16'hA55A);
  endtask

  task automatic t_no_lane;
    cyc(1'b0, 1'b0, 1'b0, 2'b11, TOP, 16'h0000);
    chk("R3 write with no lane", 2'b00, 16'h0000);
    rd("R3 read with no lane", 2'b11, TOP, 2'b00, 16'h0000);
    rd("R3 word unchanged", 2'b00, TOP, 2'b11, 16'h1234);
  endtask

  task automatic t_gate_off;
    for (int b = 0; b < 4; b++) begin
      cyc(1'b0, 1'b1, 1'b1, 2'(b), '0, 16'h0);
      chk($sformatf("R7 gate off be=%0d", b), 2'b00, 16'h0000);
    end
  endtask

  task automatic t_latency;
    rd("R9 read result next cycle", 2'b00, '0, 2'b11, 16'hA55A);
    cyc(1'b1, 1'b1, 1'b1, 2'b11, '0, 16'h0);
    chk("R9 released one cycle later", 2'b00, 16'h0000);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_full_words();
    t_byte_lanes();
    t_deselect();
    t_no_lane();
    t_gate_off();
    t_latency();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule